// File: doc/BRIEF.md
# Writeback Victim Tracker

This block sits in a processor's external bus interface. It keeps a small table of cache lines that have been evicted and are still on their way out. A line can be dirty, so a writeback is in flight, or clean, so no writeback is needed. Each table entry belongs to one victim-carrying read: a read that fills a cache line while displacing another. The entry holds the victim's line address, a dirty flag, and two completion flags. One flag is set by the writeback response, which is either an acknowledge or a cancel. The other is set by the fill reply for the read. Responses name the table slot they belong to, and that slot number is handed out when the read is accepted. The number of slots is a parameter, either 1 or 2.

The tracker answers three kinds of query, each on its own request port. The answer is registered and appears in the cycle after the request. A coherent read is either let through or held. It is held when it targets a line whose writeback has not yet been answered. A processor-side access is blocked when it touches any line that is still in the table, clean or dirty. A snoop is flagged as hitting a victim line that the block must still answer for. A clean line is answered for until its fill reply arrives. A dirty line is answered for until its writeback response arrives. Snoops, invalidating ones included, never alter the table, so a pending writeback is never withdrawn. When every slot is occupied, the block raises a stall and refuses further victim-carrying reads until a slot closes.

Top module: `wbvt_top`

## Requirements
- R1: After a synchronous reset, no slot is occupied and vic_stall, vic_ack, coh_go, coh_hold, cpu_block and snp_hit are all 0.
- R2: A victim-carrying read is accepted in a cycle where vic_req is 1 and vic_stall is 0. In the next cycle vic_ack is 1 and vic_slot holds the lowest-numbered free slot (slot 0 before slot 1). While vic_stall is 1, no request is accepted and vic_ack stays 0.
- R3: A slot is freed only after both of its responses have arrived: the writeback response (wb_resp, needed only for a dirty victim) and the fill reply (fill_resp). With NUM_SLOTS=1, a second victim-carrying read therefore waits for both responses of the first.
- R4: vic_stall is 1 exactly when all NUM_SLOTS slots are occupied. With two slots, freeing either slot clears vic_stall in the cycle after the closing response.
- R5: A coherent request gets exactly one answer, coh_go or coh_hold, in the next cycle. It gets coh_go when its line has no unanswered writeback, even while writebacks to other lines are outstanding. Every query is judged against the table as it stood before that cycle's responses.
- R6: A coherent request to the line of a dirty victim whose writeback response has not arrived gets coh_hold. The hold ends once wb_resp for that slot has arrived, even if the fill reply is still pending. A clean victim never causes a hold.
- R7: A processor-side request to the line of any occupied slot, clean or dirty, gets cpu_block until that slot is freed.
- R8: A snoop gets snp_hit while the victim is still owned. A clean victim is owned until its fill reply arrives. A dirty victim is owned until its writeback response arrives, whether or not the fill reply has come.
- R9: Snoops never change the table. After repeated snoops to a dirty victim, its writeback is still pending: coh_hold is still given for that line and vic_stall is unchanged.
- R10: When wb_resp and fill_resp name the same slot in the same cycle, both are recorded and the slot is freed. In the next cycle vic_stall drops, and snoops and processor requests to that line miss.
- R11: Addresses are compared by line. The low log2(LINE_BYTES) bits are ignored, so two addresses in the same 64-byte line match and an address in the next line does not.
- R12: A response that names a slot not in use is ignored, and occupied slots keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vic_req | input | 1 | Victim-carrying read requests a slot |
| vic_addr | input | ADDR_W | Byte address of the victim line |
| vic_dirty | input | 1 | Victim line is dirty (writeback in flight) |
| vic_stall | output | 1 | All slots occupied; request refused |
| vic_ack | output | 1 | Request accepted in the previous cycle |
| vic_slot | output | SLOT_W | Slot given to the accepted request |
| wb_resp | input | 1 | Writeback acknowledge or cancel arrives |
| wb_resp_slot | input | SLOT_W | Slot the writeback response belongs to |
| fill_resp | input | 1 | Fill reply for a victim-carrying read arrives |
| fill_resp_slot | input | SLOT_W | Slot the fill reply belongs to |
| coh_req | input | 1 | Coherent read request to be judged |
| coh_addr | input | ADDR_W | Byte address of the coherent read |
| coh_go | output | 1 | Coherent read may issue |
| coh_hold | output | 1 | Coherent read must wait for a writeback |
| cpu_req | input | 1 | Processor-side access to be judged |
| cpu_addr | input | ADDR_W | Byte address of the processor access |
| cpu_block | output | 1 | Processor access targets a victim line |
| snp_req | input | 1 | Incoming snoop to be judged |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| snp_hit | output | 1 | Snoop hits a victim line still owned |

## Verification
Two events can land on one slot in the same clock cycle: the writeback acknowledge or cancel, and the fill reply. If either is lost, the slot never closes. The bench raises both for the same dirty slot in the same cycle on the single-slot instance. It judges the outcome at the ports: the stall must fall in the next cycle, snoops and processor requests to that line must miss, and a fresh victim-carrying read must get slot 0 again. The same pair on a slot that is not in use is also driven, and it must leave the occupied slot untouched.

// File: rtl/wbvt_pkg.sv
package wbvt_pkg;

  // Per-slot status bits of the victim table.
  typedef struct packed {
    logic valid;
    logic dirty;
    logic wb_done;
    logic fill_done;
  } wbvt_flags_t;

  // A dirty victim whose writeback has not been answered yet.
  function automatic logic wb_pending(wbvt_flags_t f);
    return f.valid && f.dirty && !f.wb_done;
  endfunction

  // The victim still answers snoops: clean until fill, dirty until writeback.
  function automatic logic still_owned(wbvt_flags_t f);
    return f.valid && (f.dirty ? !f.wb_done : !f.fill_done);
  endfunction

endpackage

// File: rtl/wbvt_alloc.sv
module wbvt_alloc #(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1
) (
  input  logic [NUM_SLOTS-1:0] busy,
  output logic [SLOT_W-1:0]    free_idx,
  output logic                 any_free
);

  // Lowest-numbered free slot wins: scan downwards, last hit kept.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_idx = SLOT_W'(i);
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wbvt_table.sv
module wbvt_table
  import wbvt_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int TAG_W     = 26,
  parameter int SLOT_W    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_dirty,
  input  logic              wb_en,
  input  logic [SLOT_W-1:0] wb_idx,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_idx,
  output wbvt_flags_t       flags [NUM_SLOTS],
  output logic [TAG_W-1:0]  tags  [NUM_SLOTS],
  output logic              full_q
);

  logic [NUM_SLOTS-1:0] valid_nxt;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    wbvt_flags_t      ent_q;
    wbvt_flags_t      ent_d;
    logic [TAG_W-1:0] tag_q;
    logic             hit_alloc;
    logic             hit_wb;
    logic             hit_fill;

    assign hit_alloc = alloc_en && (alloc_idx == SLOT_W'(i));
    assign hit_wb    = wb_en    && (wb_idx    == SLOT_W'(i));
    assign hit_fill  = fill_en  && (fill_idx  == SLOT_W'(i));

    always_comb begin
      ent_d = ent_q;
      if (hit_alloc) begin
        ent_d.valid     = 1'b1;
        ent_d.dirty     = alloc_dirty;
        ent_d.wb_done   = !alloc_dirty;   // clean victims have no writeback
        ent_d.fill_done = 1'b0;
      end else if (ent_q.valid) begin
        if (hit_wb)   ent_d.wb_done   = 1'b1;
        if (hit_fill) ent_d.fill_done = 1'b1;
        if (ent_d.wb_done && ent_d.fill_done) ent_d.valid = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) ent_q <= '0;
      else     ent_q <= ent_d;
    end

    // Tag storage carries no reset so it can map onto distributed RAM.
    always_ff @(posedge clk) begin
      if (hit_alloc) tag_q <= alloc_tag;
    end

    assign flags[i]     = ent_q;
    assign tags[i]      = tag_q;
    assign valid_nxt[i] = ent_d.valid;
  end

  // Full flag precomputed from next state keeps the stall output registered.
  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else     full_q <= &valid_nxt;
  end

endmodule

// File: rtl/wbvt_match.sv
module wbvt_match
  import wbvt_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int TAG_W     = 26
) (
  input  wbvt_flags_t      flags [NUM_SLOTS],
  input  logic [TAG_W-1:0] tags  [NUM_SLOTS],
  input  logic [TAG_W-1:0] coh_tag,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             coh_pend,
  output logic             cpu_line,
  output logic             snp_own
);

  logic [NUM_SLOTS-1:0] pend_v;
  logic [NUM_SLOTS-1:0] line_v;
  logic [NUM_SLOTS-1:0] own_v;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign pend_v[i] = wb_pending(flags[i])  && (tags[i] == coh_tag);
    assign line_v[i] = flags[i].valid        && (tags[i] == cpu_tag);
    assign own_v[i]  = still_owned(flags[i]) && (tags[i] == snp_tag);
  end

  assign coh_pend = |pend_v;
  assign cpu_line = |line_v;
  assign snp_own  = |own_v;

endmodule

// File: rtl/wbvt_top.sv
module wbvt_top
  import wbvt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SLOTS  = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vic_req,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic              vic_dirty,
  output logic              vic_stall,
  output logic              vic_ack,
  output logic [SLOT_W-1:0] vic_slot,
  input  logic              wb_resp,
  input  logic [SLOT_W-1:0] wb_resp_slot,
  input  logic              fill_resp,
  input  logic [SLOT_W-1:0] fill_resp_slot,
  input  logic              coh_req,
  input  logic [ADDR_W-1:0] coh_addr,
  output logic              coh_go,
  output logic              coh_hold,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_block,
  input  logic              snp_req,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit
);

  wbvt_flags_t          flags [NUM_SLOTS];
  logic [TAG_W-1:0]     tags  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] busy;
  logic [SLOT_W-1:0]    free_idx;
  logic                 any_free;
  logic                 full_q;
  logic                 accept;
  logic                 coh_pend;
  logic                 cpu_line;
  logic                 snp_own;

  // Offsets inside a line never take part in any comparison.
  logic unused_offsets;
  assign unused_offsets = ^{vic_addr[OFF_W-1:0], coh_addr[OFF_W-1:0],
                            cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_busy
    assign busy[i] = flags[i].valid;
  end

  assign vic_stall = full_q;
  assign accept    = vic_req && !full_q;

  wbvt_alloc #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_alloc (
    .busy     (busy),
    .free_idx (free_idx),
    .any_free (any_free)
  );

  wbvt_table #(
    .NUM_SLOTS (NUM_SLOTS),
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .alloc_en    (accept),
    .alloc_idx   (free_idx),
    .alloc_tag   (vic_addr[ADDR_W-1:OFF_W]),
    .alloc_dirty (vic_dirty),
    .wb_en       (wb_resp),
    .wb_idx      (wb_resp_slot),
    .fill_en     (fill_resp),
    .fill_idx    (fill_resp_slot),
    .flags       (flags),
    .tags        (tags),
    .full_q      (full_q)
  );

  wbvt_match #(
    .NUM_SLOTS (NUM_SLOTS),
    .TAG_W     (TAG_W)
  ) u_match (
    .flags    (flags),
    .tags     (tags),
    .coh_tag  (coh_addr[ADDR_W-1:OFF_W]),
    .cpu_tag  (cpu_addr[ADDR_W-1:OFF_W]),
    .snp_tag  (snp_addr[ADDR_W-1:OFF_W]),
    .coh_pend (coh_pend),
    .cpu_line (cpu_line),
    .snp_own  (snp_own)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_ack   <= 1'b0;
      vic_slot  <= '0;
      coh_go    <= 1'b0;
      coh_hold  <= 1'b0;
      cpu_block <= 1'b0;
      snp_hit   <= 1'b0;
    end else begin
      vic_ack   <= accept;
      if (accept) vic_slot <= free_idx;
      coh_go    <= coh_req && !coh_pend;
      coh_hold  <= coh_req &&  coh_pend;
      cpu_block <= cpu_req &&  cpu_line;
      snp_hit   <= snp_req &&  snp_own;
    end
  end

endmodule

// File: rtl/wbvt_checker.sv
module wbvt_checker (
  input logic clk,
  input logic rst,
  input logic vic_req,
  input logic vic_stall,
  input logic vic_ack,
  input logic wb_resp,
  input logic fill_resp,
  input logic coh_req,
  input logic coh_go,
  input logic coh_hold,
  input logic cpu_req,
  input logic cpu_block,
  input logic snp_req,
  input logic snp_hit,
  input logic any_free
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!vic_ack && !vic_stall && !coh_go && !coh_hold && !cpu_block && !snp_hit));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (vic_req && !vic_stall) |=> vic_ack);

  p_refuse_r2: assert property (@(posedge clk) disable iff (rst)
    vic_stall |=> !vic_ack);

  p_free_needs_resp_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(vic_stall) && !$past(rst)) |-> $past(wb_resp || fill_resp));

  p_stall_vs_alloc_r4: assert property (@(posedge clk) disable iff (rst)
    vic_stall != any_free);

  p_one_answer_r5: assert property (@(posedge clk) disable iff (rst)
    coh_req |=> (coh_go != coh_hold));

  p_coh_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !coh_req |=> (!coh_go && !coh_hold));

  p_cpu_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> !cpu_block);

  p_snp_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !snp_req |=> !snp_hit);

endmodule

bind wbvt_top wbvt_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .vic_req   (vic_req),
  .vic_stall (vic_stall),
  .vic_ack   (vic_ack),
  .wb_resp   (wb_resp),
  .fill_resp (fill_resp),
  .coh_req   (coh_req),
  .coh_go    (coh_go),
  .coh_hold  (coh_hold),
  .cpu_req   (cpu_req),
  .cpu_block (cpu_block),
  .snp_req   (snp_req),
  .snp_hit   (snp_hit),
  .any_free  (any_free)
);

// File: tb/wbvt_top_tb.sv
`timescale 1ns/1ps
module wbvt_top_tb;

  localparam int CLK_NS = 20;
  localparam logic [31:0] LA = 32'h0000_1000;
  localparam logic [31:0] LB = 32'h0000_2040;
  localparam logic [31:0] LC = 32'h0000_3080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vic_req = 1'b0, vic_dirty = 1'b0;
  logic [31:0] vic_addr = '0;
  logic        wb_resp = 1'b0, fill_resp = 1'b0;
  logic        wb_slot = 1'b0, fill_slot = 1'b0;
  logic        coh_req = 1'b0, cpu_req = 1'b0, snp_req = 1'b0;
  logic [31:0] coh_addr = '0, cpu_addr = '0, snp_addr = '0;

  logic stall, ack, slot, cgo, chold, cblk, shit;
  logic s1_stall, s1_ack, s1_slot, s1_cgo, s1_chold, s1_cblk, s1_shit;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  wbvt_top #(.NUM_SLOTS(2)) u_dut (
    .clk(clk), .rst(rst), .vic_req(vic_req), .vic_addr(vic_addr), .vic_dirty(vic_dirty),
    .vic_stall(stall), .vic_ack(ack), .vic_slot(slot),
    .wb_resp(wb_resp), .wb_resp_slot(wb_slot), .fill_resp(fill_resp), .fill_resp_slot(fill_slot),
    .coh_req(coh_req), .coh_addr(coh_addr), .coh_go(cgo), .coh_hold(chold),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_block(cblk),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_hit(shit));

  wbvt_top #(.NUM_SLOTS(1)) u_dut1 (
    .clk(clk), .rst(rst), .vic_req(vic_req), .vic_addr(vic_addr), .vic_dirty(vic_dirty),
    .vic_stall(s1_stall), .vic_ack(s1_ack), .vic_slot(s1_slot),
    .wb_resp(wb_resp), .wb_resp_slot(wb_slot), .fill_resp(fill_resp), .fill_resp_slot(fill_slot),
    .coh_req(coh_req), .coh_addr(coh_addr), .coh_go(s1_cgo), .coh_hold(s1_chold),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_block(s1_cblk),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_hit(s1_shit));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    vic_req = 0; wb_resp = 0; fill_resp = 0; coh_req = 0; cpu_req = 0; snp_req = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic victim(logic [31:0] a, logic d);
    vic_req = 1'b1; vic_addr = a; vic_dirty = d;
    tick();
    vic_req = 1'b0;
  endtask

  task automatic resp(logic w, logic ws, logic f, logic fs);
    wb_resp = w; wb_slot = ws; fill_resp = f; fill_slot = fs;
    tick();
    wb_resp = 1'b0; fill_resp = 1'b0;
  endtask

  task automatic query(logic [31:0] a);
    coh_req = 1'b1; cpu_req = 1'b1; snp_req = 1'b1;
    coh_addr = a; cpu_addr = a; snp_addr = a;
    tick();
    coh_req = 1'b0; cpu_req = 1'b0; snp_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    tick();
    chk("R1 stall", stall, 0);   chk("R1 ack", ack, 0);
    chk("R1 coh_go", cgo, 0);    chk("R1 coh_hold", chold, 0);
    chk("R1 cpu_block", cblk, 0); chk("R1 snp_hit", shit, 0);
    chk("R1 one-slot stall", s1_stall, 0);
  endtask

  task automatic t_fill_slots();
    do_reset();
    victim(LA, 1);
    chk("R2 ack first", ack, 1); chk("R2 slot first", slot, 0); chk("R4 not full", stall, 0);
    victim(LB, 0);
    chk("R2 ack second", ack, 1); chk("R2 slot second", slot, 1); chk("R4 full", stall, 1);
    victim(LC, 0);
    chk("R2 refused while full", ack, 0); chk("R4 still full", stall, 1);
    resp(0, 0, 1, 1);
    chk("R4 stall drops after close", stall, 0);
    victim(LC, 0);
    chk("R2 reuse ack", ack, 1); chk("R2 reuse slot", slot, 1);
  endtask

  task automatic t_single_slot();
    do_reset();
    victim(LA, 1);
    chk("R3 one-slot ack", s1_ack, 1); chk("R3 one-slot full", s1_stall, 1);
    victim(LB, 0);
    chk("R3 second refused", s1_ack, 0);
    resp(1, 0, 0, 0);
    chk("R3 writeback alone keeps slot", s1_stall, 1);
    victim(LB, 0);
    chk("R3 still refused", s1_ack, 0);
    resp(0, 0, 1, 0);
    chk("R3 freed after both", s1_stall, 0);
    victim(LB, 0);
    chk("R3 next accepted", s1_ack, 1);
  endtask

  task automatic t_coherent();
    do_reset();
    victim(LA, 1); victim(LB, 0);
    query(LA + 32'h3C);
    chk("R6 R11 hold same line", chold, 1); chk("R6 no go", cgo, 0);
    query(LA + 32'h40);
    chk("R11 next line goes", cgo, 1); chk("R11 next line no hold", chold, 0);
    query(LC);
    chk("R5 unrelated goes", cgo, 1);
    query(LB);
    chk("R6 clean victim no hold", cgo, 1);
    resp(1, 0, 0, 0);
    query(LA);
    chk("R6 released by writeback", cgo, 1); chk("R6 hold gone", chold, 0);
    chk("R7 still blocked fill pending", cblk, 1);
  endtask

  task automatic t_cpu();
    do_reset();
    victim(LA, 0); victim(LB, 1);
    query(LA); chk("R7 clean blocked", cblk, 1);
    query(LB); chk("R7 dirty blocked", cblk, 1);
    query(LC); chk("R7 other free", cblk, 0);
    resp(1, 1, 0, 0);
    query(LB); chk("R7 dirty blocked until fill", cblk, 1);
    resp(0, 0, 1, 0);
    query(LA); chk("R7 clean released", cblk, 0);
    resp(0, 0, 1, 1);
    query(LB); chk("R7 dirty released", cblk, 0);
  endtask

  task automatic t_snoop();
    do_reset();
    victim(LA, 1); victim(LB, 0);
    query(LA); chk("R8 dirty owned", shit, 1);
    query(LB); chk("R8 clean owned", shit, 1);
    resp(0, 0, 1, 0);
    query(LA); chk("R8 dirty owned after fill", shit, 1);
    resp(0, 0, 1, 1);
    query(LB); chk("R8 clean released by fill", shit, 0);
    resp(1, 0, 0, 0);
    query(LA); chk("R8 dirty released by writeback", shit, 0);
  endtask

  task automatic t_invalidate();
    do_reset();
    victim(LA, 1);
    snp_req = 1'b1; snp_addr = LA;
    tick(); tick(); tick();
    snp_req = 1'b0;
    chk("R9 snoop hits", shit, 1);
    chk("R9 one-slot snoop hits", s1_shit, 1);
    query(LA);
    chk("R9 writeback still pending", chold, 1);
    chk("R9 one-slot hold", s1_chold, 1);
    chk("R9 one-slot stall kept", s1_stall, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    victim(LA, 1);
    resp(1, 0, 1, 0);
    chk("R10 one-slot freed", s1_stall, 0);
    chk("R10 two-slot not full", stall, 0);
    query(LA);
    chk("R10 snoop misses", s1_shit, 0); chk("R10 cpu free", s1_cblk, 0);
    victim(LB, 1);
    chk("R10 new ack", s1_ack, 1); chk("R10 slot zero", s1_slot, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    victim(LA, 1);
    resp(1, 1, 1, 1);
    query(LA);
    chk("R12 snoop still hits", shit, 1); chk("R12 cpu still blocked", cblk, 1);
    chk("R12 hold kept", chold, 1);
    chk("R12 one-slot snoop hits", s1_shit, 1); chk("R12 one-slot stall", s1_stall, 1);
    victim(LB, 0);
    chk("R12 unused slot free", ack, 1); chk("R12 unused slot index", slot, 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_err++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_fill_slots();
    t_single_slot();
    t_coherent();
    t_cpu();
    t_snoop();
    t_invalidate();
    t_same_cycle();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule